// File: doc/BRIEF.md
# Boot Image Copy Engine

This block keeps a short boot program in a 1024-byte retention memory that stays powered while the rest of the chip sleeps. On request it copies that program, one 32-bit dword per clock, into an instruction memory through a single write port. A host reaches the block through a 32-bit register interface. That interface holds a control word, a source word index, a destination byte address and a dword count. It also gives dword access to the retention memory through a window above the registers.

A copy starts in one of two ways. The host can write the start bit, which then reads back as 1 until the last dword has been written, so software can poll it for completion. The host can also set a sticky arm bit. While the arm bit is set, every power-up pulse re-runs the same copy without any host action. When a copy ends, a status flag is set. A new copy clears that flag when it begins.

Top module: `boot_copy_engine`

## Requirements
- R1: After reset, the control word and the status word read 0 and the destination write enable is low.
- R2: Writing a control word with bit 31 set starts a copy. Control bit 31 reads 1 while the copy runs and returns to 0 by itself after the last dword has been written.
- R3: Status bit 0 is 1 once the most recent copy has finished. It is 0 while a copy with a nonzero count runs.
- R4: A copy of N dwords drives N consecutive cycles of destination write enable. The first write appears on the cycle after the start is accepted. Write k (counted from 0) carries address dst + 4k and the retention word at index src + k.
- R5: The source word index wraps modulo the 256-dword memory size.
- R6: A start with a count of 0 sets status bit 0 on the next cycle, leaves control bit 31 at 0 and produces no destination write.
- R7: A start request from a host write or a power-up pulse has no effect while a copy is in progress. The running copy writes exactly its programmed count.
- R8: Control bit 30 is a sticky arm bit that reads back as written. While it is 1, a power-up pulse starts the copy with the current register values. While it is 0, a power-up pulse does nothing.
- R9: Byte addresses from 0x400 to 0x7FC access the retention memory, with word index equal to (address - 0x400)/4. Its contents are unchanged by copies and power-up pulses.
- R10: The registers sit at byte address 0x000 (control), 0x004 (source index, 8 bits), 0x008 (destination address), 0x00C (count, 9 bits) and 0x010 (status). Read data appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | 11 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, registered |
| pwr_up | input | 1 | Power-up event pulse |
| imem_we | output | 1 | Instruction memory write enable |
| imem_addr | output | 32 | Instruction memory byte address |
| imem_wdata | output | 32 | Instruction memory write data |

## Verification
The bench builds the block with its defaults: 256 dwords of retention memory and 32-bit data. With these values the source index wraps from 255 to 0, so one copy can be placed across the end of memory. The 9-bit count can express both zero and a copy longer than the bench's restart attempts. A behavioural model follows every host access and power-up pulse and predicts the write port on every clock.

// File: rtl/bce_pkg.sv
package bce_pkg;
    typedef enum logic [2:0] {
        RI_CTRL = 3'd0,
        RI_SRC  = 3'd1,
        RI_DST  = 3'd2,
        RI_CNT  = 3'd3,
        RI_STAT = 3'd4
    } reg_idx_e;

    localparam int CTRL_START_BIT = 31;
    localparam int CTRL_ARM_BIT   = 30;
endpackage

// File: rtl/bce_retain_mem.sv
module bce_retain_mem #(
    parameter int DEPTH = 256,
    parameter int W     = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_a_idx,
    output logic [W-1:0]  rd_a_data,
    input  logic [IW-1:0] rd_b_idx,
    output logic [W-1:0]  rd_b_data
);
    // No reset: contents survive everything but loss of power.
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_idx] <= wr_data;
    end

    assign rd_a_data = cells[rd_a_idx];
    assign rd_b_data = cells[rd_b_idx];
endmodule

// File: rtl/bce_sequencer.sv
module bce_sequencer #(
    parameter int DEPTH = 256,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [IW-1:0] cfg_src,
    input  logic [DW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_cnt,
    output logic [IW-1:0] mem_idx,
    input  logic [DW-1:0] mem_data,
    output logic          busy,
    output logic          done,
    output logic          imem_we,
    output logic [DW-1:0] imem_addr,
    output logic [DW-1:0] imem_wdata
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] rem;
        logic [IW-1:0] src;
        logic [DW-1:0] dst;
        logic          we;
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.we = 1'b0;
        if (s_q.busy) begin
            s_d.we   = 1'b1;
            s_d.addr = s_q.dst;
            s_d.data = mem_data;
            s_d.src  = s_q.src + 1'b1;
            s_d.dst  = s_q.dst + DW'(4);
            s_d.rem  = s_q.rem - 1'b1;
            if (s_q.rem == CW'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end else if (go) begin
            s_d.src = cfg_src;
            s_d.dst = cfg_dst;
            s_d.rem = cfg_cnt;
            if (cfg_cnt == '0) begin
                s_d.done = 1'b1;
            end else begin
                s_d.busy = 1'b1;
                s_d.done = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_idx    = s_q.src;
    assign busy       = s_q.busy;
    assign done       = s_q.done;
    assign imem_we    = s_q.we;
    assign imem_addr  = s_q.addr;
    assign imem_wdata = s_q.data;

    a_r4_we_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.we |-> $past(s_q.busy));
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.we && $past(s_q.we) |-> s_q.addr == $past(s_q.addr) + DW'(4));
    a_r3_done_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.busy && s_q.done));
    a_r6_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy && go && cfg_cnt == '0 |=> s_q.done && !s_q.busy && !s_q.we);
    a_r7_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && go && s_q.rem > CW'(1) |=> s_q.busy && s_q.rem == $past(s_q.rem) - 1'b1);
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine #(
    parameter int MEM_DWORDS = 256,
    parameter int DW         = 32,
    localparam int IW        = $clog2(MEM_DWORDS),
    localparam int CW        = IW + 1,
    localparam int AW        = IW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hst_wr,
    input  logic          hst_rd,
    input  logic [AW-1:0] hst_addr,
    input  logic [DW-1:0] hst_wdata,
    output logic [DW-1:0] hst_rdata,
    input  logic          pwr_up,
    output logic          imem_we,
    output logic [DW-1:0] imem_addr,
    output logic [DW-1:0] imem_wdata
);
    import bce_pkg::*;

    typedef struct packed {
        logic          arm;
        logic [IW-1:0] src;
        logic [DW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic          win_sel, reg_sel, host_go, go, busy, done;
    logic [2:0]    ridx;
    logic [IW-1:0] seq_idx;
    logic [DW-1:0] seq_word, host_word;

    assign win_sel = hst_addr[AW-1];
    assign reg_sel = !win_sel && (hst_addr[AW-2:5] == '0);
    assign ridx    = hst_addr[4:2];
    assign host_go = hst_wr && reg_sel && ridx == RI_CTRL && hst_wdata[CTRL_START_BIT];
    assign go      = host_go || (pwr_up && r_q.arm);

    bce_retain_mem #(.DEPTH(MEM_DWORDS), .W(DW)) u_mem (
        .clk       (clk),
        .wr_en     (hst_wr && win_sel),
        .wr_idx    (hst_addr[IW+1:2]),
        .wr_data   (hst_wdata),
        .rd_a_idx  (seq_idx),
        .rd_a_data (seq_word),
        .rd_b_idx  (hst_addr[IW+1:2]),
        .rd_b_data (host_word)
    );

    bce_sequencer #(.DEPTH(MEM_DWORDS), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .cfg_src    (r_q.src),
        .cfg_dst    (r_q.dst),
        .cfg_cnt    (r_q.cnt),
        .mem_idx    (seq_idx),
        .mem_data   (seq_word),
        .busy       (busy),
        .done       (done),
        .imem_we    (imem_we),
        .imem_addr  (imem_addr),
        .imem_wdata (imem_wdata)
    );

    always_comb begin
        r_d = r_q;
        if (hst_wr && reg_sel) begin
            unique case (ridx)
                RI_CTRL: r_d.arm = hst_wdata[CTRL_ARM_BIT];
                RI_SRC:  r_d.src = hst_wdata[IW-1:0];
                RI_DST:  r_d.dst = hst_wdata;
                RI_CNT:  r_d.cnt = hst_wdata[CW-1:0];
                default: ;
            endcase
        end
        if (hst_rd) begin
            r_d.rdata = '0;
            if (win_sel) begin
                r_d.rdata = host_word;
            end else if (reg_sel) begin
                unique case (ridx)
                    RI_CTRL: begin
                        r_d.rdata[CTRL_START_BIT] = busy;
                        r_d.rdata[CTRL_ARM_BIT]   = r_q.arm;
                    end
                    RI_SRC:  r_d.rdata[IW-1:0] = r_q.src;
                    RI_DST:  r_d.rdata         = r_q.dst;
                    RI_CNT:  r_d.rdata[CW-1:0] = r_q.cnt;
                    RI_STAT: r_d.rdata[0]      = done;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hst_rdata = r_q.rdata;

    a_r8_unarmed_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.arm && pwr_up && !hst_wr && !busy |=> !busy && !imem_we);
    a_r2_host_start: assert property (@(posedge clk) disable iff (!rst_n)
        host_go && !busy && r_q.cnt != '0 |=> busy && !done);
endmodule

// File: tb/sim_boot_copy_engine.sv
module sim_boot_copy_engine;
    localparam int MW = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr = 1'b0, hst_rd = 1'b0, pwr_up = 1'b0;
    logic [10:0] hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata, imem_addr, imem_wdata;
    logic        imem_we;

    int n_tests = 0, n_fail = 0, n_we = 0, cyc = 0;

    always #10 clk = ~clk;

    boot_copy_engine u0 (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .pwr_up(pwr_up), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata)
    );

    // Behavioural model
    logic [31:0] m_mem [MW];
    bit          m_busy, m_done, m_arm, m_we;
    int          m_rem, m_src, m_dst, m_rsrc, m_rcnt;
    logic [31:0] m_rdst, m_addr, m_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_arm <= 0; m_we <= 0;
            m_rsrc <= 0; m_rdst <= 0; m_rcnt <= 0;
        end else begin
            bit start;
            start = (hst_wr && hst_addr == 11'h000 && hst_wdata[31]) || (pwr_up && m_arm);
            m_we <= 0;
            if (m_busy) begin
                m_we <= 1; m_addr <= m_dst; m_data <= m_mem[m_src];
                m_src <= (m_src + 1) % MW; m_dst <= m_dst + 4; m_rem <= m_rem - 1;
                if (m_rem == 1) begin m_busy <= 0; m_done <= 1; end
            end else if (start) begin
                m_src <= m_rsrc; m_dst <= m_rdst; m_rem <= m_rcnt;
                if (m_rcnt == 0) m_done <= 1;
                else begin m_busy <= 1; m_done <= 0; end
            end
            if (hst_wr) begin
                if (hst_addr >= 11'h400) m_mem[(hst_addr - 11'h400) / 4] <= hst_wdata;
                else if (hst_addr == 11'h000) m_arm <= hst_wdata[30];
                else if (hst_addr == 11'h004) m_rsrc <= int'(hst_wdata[7:0]);
                else if (hst_addr == 11'h008) m_rdst <= hst_wdata;
                else if (hst_addr == 11'h00C) m_rcnt <= int'(hst_wdata[8:0]);
            end
        end
    end

    // Per-clock comparison of the write port
    always @(negedge clk) begin
        if (rst_n) begin
            n_tests++;
            if (imem_we !== m_we || (m_we && (imem_addr !== m_addr || imem_wdata !== m_data))) begin
                n_fail++;
                $display("FAIL R4 R5 port: we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h",
                         imem_we, imem_addr, imem_wdata, m_we, m_addr, m_data);
            end
            if (imem_we) n_we++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] pat(int i);
        return 32'hA500_0000 ^ (i * 32'h0001_0203);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [10:0] a, logic [31:0] d);
        hst_wr = 1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_wr = 0;
    endtask

    task automatic rd(logic [10:0] a, output logic [31:0] d);
        hst_rd = 1; hst_addr = a;
        @(negedge clk);
        hst_rd = 0;
        d = hst_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(11'h000, v);
            if (!v[31]) break;
        end
    endtask

    initial begin
        logic [31:0] v;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        rd(11'h000, v); check("R1 ctrl", v, 32'h0);
        rd(11'h010, v); check("R1 status", v, 32'h0);
        check("R1 we", {31'b0, imem_we}, 32'h0);

        // R9: fill window
        for (int i = 0; i < MW; i++) wr(11'h400 + 11'(i * 4), pat(i));
        rd(11'h404, v); check("R9 window word 1", v, pat(1));
        rd(11'h7FC, v); check("R9 window word 255", v, pat(255));

        // R10 readback
        wr(11'h004, 32'd4); wr(11'h008, 32'h0000_1000); wr(11'h00C, 32'd5);
        rd(11'h004, v); check("R10 src", v, 32'd4);
        rd(11'h008, v); check("R10 dst", v, 32'h1000);
        rd(11'h00C, v); check("R10 cnt", v, 32'd5);

        // R2 / R3
        n_we = 0;
        wr(11'h000, 32'h8000_0000);
        rd(11'h000, v); check("R2 start reads 1", v, 32'h8000_0000);
        rd(11'h010, v); check("R3 status clear while busy", v, 32'h0);
        wait_idle();
        check("R2 start self clears", v & 32'h8000_0000, 32'h0);
        rd(11'h010, v); check("R3 done", v, 32'h1);
        check("R4 write count", n_we, 32'd5);

        // R5 wrap
        wr(11'h004, 32'd254); wr(11'h00C, 32'd4); n_we = 0;
        wr(11'h000, 32'h8000_0000);
        wait_idle();
        check("R5 wrap write count", n_we, 32'd4);

        // R6 zero count
        wr(11'h00C, 32'd0); n_we = 0;
        wr(11'h000, 32'h8000_0000);
        rd(11'h000, v); check("R6 ctrl", v, 32'h0);
        rd(11'h010, v); check("R6 done", v, 32'h1);
        check("R6 no write", n_we, 32'd0);

        // R7 restart ignored
        wr(11'h00C, 32'd20); wr(11'h004, 32'd0); n_we = 0;
        wr(11'h000, 32'h8000_0000);
        @(negedge clk);
        wr(11'h00C, 32'd3);
        wr(11'h000, 32'h8000_0000);
        wait_idle();
        check("R7 count kept", n_we, 32'd20);

        // R8 unarmed pulse
        n_we = 0;
        pwr_up = 1; @(negedge clk); pwr_up = 0;
        repeat (4) @(negedge clk);
        check("R8 unarmed no write", n_we, 32'd0);
        wr(11'h000, 32'h4000_0000);
        rd(11'h000, v); check("R8 arm reads back", v, 32'h4000_0000);
        pwr_up = 1; @(negedge clk); pwr_up = 0;
        rd(11'h000, v); check("R8 armed pulse starts", v, 32'hC000_0000);
        wait_idle();
        check("R8 armed copy count", n_we, 32'd3);
        rd(11'h010, v); check("R8 done", v, 32'h1);

        // R9 retention
        rd(11'h400, v); check("R9 retained word 0", v, pat(0));
        rd(11'h408, v); check("R9 retained word 2", v, pat(2));

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule